// File: doc/BRIEF.md
# Sprite Pixel Fetch and Colour Lookup

This block overlays one 64x64 sprite on a 1024x768 raster. Each cycle it is given the raster coordinate of the current pixel, its blanking and sync flags, and the sprite's memory base word and screen corner. Sprite pixels sit in memory as 6-bit palette indices packed six to a 36-bit word, row after row, so one sprite fills 683 consecutive words. The block works out when the raster lies in the sprite window, and at the first pixel of every six-pixel group, and at the first pixel of every sprite row, it issues a read for the word holding that pixel.

Returned words land in a two-entry buffer selected by the low address bit. The raster information travels down a delay line matched to the memory's fixed read latency, so each word is in the buffer when its first pixel reaches the unpack stage. The unpacked index is looked up in a writable 64-entry table of 24-bit colours. Outside the window, during blanking, and optionally for index 0, the output is a programmable background colour. Sync and enable flags are delayed to line up with the colour.

Top module: `sprite_fetch_palette`

## Requirements
- R1: A raster pixel is inside the sprite when its enable is high, spr_x <= pix_x < spr_x+64 and spr_y <= pix_y < spr_y+64; no memory request results from a pixel outside it.
- R2: For an inside pixel with col = pix_x-spr_x, row = pix_y-spr_y and k = row*64+col, a request is raised in the next cycle exactly when col = 0 or k mod 6 = 0, with mem_addr = spr_base + k/6 (modulo the address width).
- R3: No request is raised for an inside pixel that neither starts a row nor starts a six-pixel group.
- R4: Slot k mod 6 of a word holds the pixel's index, slot 0 at bits [35:30] and slot s at bits [35-6s : 30-6s].
- R5: For an inside pixel the colour output equals the table entry for its index, MEM_LAT+3 cycles after the pixel is presented, with mem_rvalid returning data MEM_LAT cycles after the request cycle.
- R6: For a pixel outside the sprite, including blanking, the colour output equals bg_rgb.
- R7: With transp_en high an inside pixel of index 0 shows bg_rgb; with transp_en low it shows table entry 0.
- R8: out_de, out_hs and out_vs equal pix_de, pix_hs and pix_vs delayed by MEM_LAT+3 cycles.
- R9: A table write (pal_we with pal_waddr, pal_wdata) changes the colour shown for that index in later frames.
- R10: A six-pixel group whose word begins on the previous sprite row is shown correctly at the start of the next row.
- R11: During reset mem_req, rgb_out, out_de, out_hs and out_vs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 10 | Raster column |
| pix_y | input | 10 | Raster row |
| pix_de | input | 1 | Raster active-video flag |
| pix_hs | input | 1 | Raster horizontal sync |
| pix_vs | input | 1 | Raster vertical sync |
| spr_base | input | 19 | Memory word holding the sprite's first pixel |
| spr_x | input | 10 | Sprite left column |
| spr_y | input | 10 | Sprite top row |
| transp_en | input | 1 | Show background for index 0 |
| bg_rgb | input | 24 | Background colour |
| pal_we | input | 1 | Colour table write strobe |
| pal_waddr | input | 6 | Colour table write index |
| pal_wdata | input | 24 | Colour table write value |
| mem_req | output | 1 | Read request |
| mem_addr | output | 19 | Read word address |
| mem_rvalid | input | 1 | Read data valid, fixed latency after request |
| mem_rdata | input | 36 | Read data word |
| rgb_out | output | 24 | Pixel colour |
| out_de | output | 1 | Delayed active-video flag |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The bench aims at sprites pinned to the top-left and bottom-right screen corners, a base near the top of the address space so word addresses wrap, and rows whose first group reuses the word that ended the previous row; a design that fetched only on group boundaries would show stale pixels at those row starts. It models memory with a fixed latency and compares each pixel against a packed-word model, so a reversed slot order or a latency mismatch of one stage shows as wrong colours across the whole sprite. Transparency is run on and off with a non-zero entry 0, and a table entry is rewritten between frames, which catches a palette that ignores writes or treats index 0 as transparent unconditionally.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;
endpackage

// File: rtl/sprite_locate.sv
`timescale 1ns/1ps
module sprite_locate #(
  parameter int XW  = 10,
  parameter int YW  = 10,
  parameter int AW  = 19,
  parameter int SPR = 64,
  parameter int PPW = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [XW-1:0]              pix_x,
  input  logic [YW-1:0]              pix_y,
  input  logic                       pix_de,
  input  logic [XW-1:0]              spr_x,
  input  logic [YW-1:0]              spr_y,
  input  logic [AW-1:0]              spr_base,
  output logic                       in_spr,
  output logic [$clog2(PPW)-1:0]     slot,
  output logic                       par,
  output logic                       req_q,
  output logic [AW-1:0]              addr_q
);
  localparam int CW    = $clog2(SPR);
  localparam int IDXW  = 2 * CW;
  localparam int SLOTW = $clog2(PPW);
  localparam logic [IDXW-1:0] PPW_V = IDXW'(PPW);
  localparam logic [XW:0]     SPR_XV = (XW+1)'(SPR);
  localparam logic [YW:0]     SPR_YV = (YW+1)'(SPR);

  logic [XW:0]     dx;
  logic [YW:0]     dy;
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] woff;
  logic [AW-1:0]   addr_d;
  logic            req_d;

  always_comb begin
    dx     = {1'b0, pix_x} - {1'b0, spr_x};
    dy     = {1'b0, pix_y} - {1'b0, spr_y};
    in_spr = pix_de && (dx < SPR_XV) && (dy < SPR_YV);
    idx    = {dy[CW-1:0], dx[CW-1:0]};
    woff   = idx / PPW_V;
    slot   = SLOTW'(idx % PPW_V);
    addr_d = spr_base + AW'(woff);
    par    = addr_d[0];
    req_d  = in_spr && ((dx[CW-1:0] == '0) || (slot == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= req_d;
      if (req_d) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/sprite_word_buf.sv
`timescale 1ns/1ps
module sprite_word_buf #(
  parameter int WORDW = 36,
  parameter int PIXW  = 6,
  parameter int PPW   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [WORDW-1:0]       wr_word,
  input  logic                   rd_sel,
  input  logic [$clog2(PPW)-1:0] rd_slot,
  output logic [PIXW-1:0]        pix
);
  localparam int SLOTW = $clog2(PPW);
  localparam int LANES = 1 << SLOTW;

  logic [WORDW-1:0] bank [2];
  logic [WORDW-1:0] cur;
  logic [PIXW-1:0]  lane [LANES];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         bank[b] <= '0;
      else if (wr_en && (wr_sel == 1'(b))) bank[b] <= wr_word;
    end
  end

  assign cur = bank[rd_sel];

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    if (s < PPW) begin : g_used
      assign lane[s] = cur[WORDW-1-s*PIXW -: PIXW];
    end else begin : g_pad
      assign lane[s] = '0;
    end
  end

  assign pix = lane[rd_slot];
endmodule

// File: rtl/sprite_palette.sv
`timescale 1ns/1ps
module sprite_palette #(
  parameter int PIXW = 6,
  parameter int RGBW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PIXW-1:0] waddr,
  input  logic [RGBW-1:0] wdata,
  input  logic            show_spr,
  input  logic [PIXW-1:0] pix,
  input  logic            transp_en,
  input  logic [RGBW-1:0] bg_rgb,
  output logic [RGBW-1:0] rgb
);
  localparam int PALN = 1 << PIXW;

  logic [RGBW-1:0] tab [PALN];
  logic [RGBW-1:0] rgb_d;
  logic            opaque;

  always_ff @(posedge clk) begin
    if (we) tab[waddr] <= wdata;
  end

  always_comb begin
    opaque = show_spr && !(transp_en && (pix == '0));
    rgb_d  = opaque ? tab[pix] : bg_rgb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb <= '0;
    else        rgb <= rgb_d;
  end
endmodule

// File: rtl/sprite_fetch_palette.sv
`timescale 1ns/1ps
module sprite_fetch_palette #(
  parameter int XW      = 10,
  parameter int YW      = 10,
  parameter int AW      = 19,
  parameter int SPR     = 64,
  parameter int PIXW    = 6,
  parameter int WORDW   = 36,
  parameter int RGBW    = 24,
  parameter int MEM_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW-1:0]    pix_x,
  input  logic [YW-1:0]    pix_y,
  input  logic             pix_de,
  input  logic             pix_hs,
  input  logic             pix_vs,
  input  logic [AW-1:0]    spr_base,
  input  logic [XW-1:0]    spr_x,
  input  logic [YW-1:0]    spr_y,
  input  logic             transp_en,
  input  logic [RGBW-1:0]  bg_rgb,
  input  logic             pal_we,
  input  logic [PIXW-1:0]  pal_waddr,
  input  logic [RGBW-1:0]  pal_wdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [WORDW-1:0] mem_rdata,
  output logic [RGBW-1:0]  rgb_out,
  output logic             out_de,
  output logic             out_hs,
  output logic             out_vs
);
  import spr_pkg::*;

  localparam int PPW   = WORDW / PIXW;
  localparam int SLOTW = $clog2(PPW);
  localparam int DEPTH = MEM_LAT + 2;
  localparam int WR_ST = MEM_LAT;
  localparam int RD_ST = MEM_LAT + 1;

  typedef struct packed {
    logic             in_spr;
    logic [SLOTW-1:0] slot;
    logic             par;
    sync_t            sy;
  } stage_t;

  logic             in_spr;
  logic [SLOTW-1:0] slot;
  logic             par;
  stage_t           stg0_d;
  stage_t           stg [DEPTH];
  logic [PIXW-1:0]  pix;
  sync_t            sync_q;

  sprite_locate #(.XW(XW), .YW(YW), .AW(AW), .SPR(SPR), .PPW(PPW)) loc_i (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
    .spr_x(spr_x), .spr_y(spr_y), .spr_base(spr_base),
    .in_spr(in_spr), .slot(slot), .par(par), .req_q(mem_req), .addr_q(mem_addr)
  );

  always_comb begin
    stg0_d.in_spr = in_spr;
    stg0_d.slot   = slot;
    stg0_d.par    = par;
    stg0_d.sy.hs  = pix_hs;
    stg0_d.sy.vs  = pix_vs;
    stg0_d.sy.de  = pix_de;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[k] <= '0;
      else if (k == 0) stg[k] <= stg0_d;
      else             stg[k] <= stg[(k == 0) ? 0 : k-1];
    end
  end

  sprite_word_buf #(.WORDW(WORDW), .PIXW(PIXW), .PPW(PPW)) buf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(mem_rvalid), .wr_sel(stg[WR_ST].par),
    .wr_word(mem_rdata), .rd_sel(stg[RD_ST].par), .rd_slot(stg[RD_ST].slot), .pix(pix)
  );

  sprite_palette #(.PIXW(PIXW), .RGBW(RGBW)) pal_i (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .show_spr(stg[RD_ST].in_spr), .pix(pix), .transp_en(transp_en),
    .bg_rgb(bg_rgb), .rgb(rgb_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= stg[RD_ST].sy;
  end

  assign out_hs = sync_q.hs;
  assign out_vs = sync_q.vs;
  assign out_de = sync_q.de;
endmodule

// File: rtl/sprite_fetch_palette_chk.sv
`timescale 1ns/1ps
module sprite_fetch_palette_chk #(
  parameter int XW      = 10,
  parameter int YW      = 10,
  parameter int AW      = 19,
  parameter int SPR     = 64,
  parameter int PIXW    = 6,
  parameter int WORDW   = 36,
  parameter int RGBW    = 24,
  parameter int MEM_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XW-1:0]    pix_x,
  input logic [YW-1:0]    pix_y,
  input logic             pix_de,
  input logic             pix_hs,
  input logic             pix_vs,
  input logic [AW-1:0]    spr_base,
  input logic [XW-1:0]    spr_x,
  input logic [YW-1:0]    spr_y,
  input logic             transp_en,
  input logic [RGBW-1:0]  bg_rgb,
  input logic             pal_we,
  input logic [PIXW-1:0]  pal_waddr,
  input logic [RGBW-1:0]  pal_wdata,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_rvalid,
  input logic [WORDW-1:0] mem_rdata,
  input logic [RGBW-1:0]  rgb_out,
  input logic             out_de,
  input logic             out_hs,
  input logic             out_vs
);
  localparam int TOT   = MEM_LAT + 3;
  localparam int PPW   = WORDW / PIXW;
  localparam int WORDS = (SPR * SPR + PPW - 1) / PPW;
  localparam logic [AW-1:0] WORDS_V = AW'(WORDS);

  logic          in_win;
  logic [XW:0]   cdx;
  logic [YW:0]   cdy;
  logic [2:0]    syn_q [TOT];
  logic          armed;

  always_comb begin
    cdx    = {1'b0, pix_x} - {1'b0, spr_x};
    cdy    = {1'b0, pix_y} - {1'b0, spr_y};
    in_win = pix_de && (cdx < (XW+1)'(SPR)) && (cdy < (YW+1)'(SPR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      for (int k = 0; k < TOT; k++) syn_q[k] <= '0;
    end else begin
      armed    <= 1'b1;
      syn_q[0] <= {pix_hs, pix_vs, pix_de};
      for (int k = 1; k < TOT; k++) syn_q[k] <= syn_q[k-1];
    end
  end

  // R1: a request only follows an inside pixel
  a_r1_no_req_outside: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(in_win));

  // R2: every requested word lies within the sprite's 683 words
  a_r2_addr_in_sprite: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr - $past(spr_base)) < WORDS_V));

  // R8: flags are delayed by the full pipeline depth
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    {out_hs, out_vs, out_de} == syn_q[TOT-1]);

  // R6: blanking shows the background colour
  a_r6_bg_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !out_de) |-> (rgb_out == $past(bg_rgb)));
endmodule

bind sprite_fetch_palette sprite_fetch_palette_chk #(
  .XW(XW), .YW(YW), .AW(AW), .SPR(SPR), .PIXW(PIXW),
  .WORDW(WORDW), .RGBW(RGBW), .MEM_LAT(MEM_LAT)
) chk_i (.*);

// File: tb/sprite_fetch_palette_tb_top.sv
`timescale 1ns/1ps
module sprite_fetch_palette_tb_top;
  localparam int MEM_LAT = 3;
  localparam int TOT     = MEM_LAT + 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  pix_x, pix_y, spr_x, spr_y;
  logic        pix_de, pix_hs, pix_vs, transp_en;
  logic [18:0] spr_base;
  logic [23:0] bg_rgb;
  logic        pal_we;
  logic [5:0]  pal_waddr;
  logic [23:0] pal_wdata;
  logic        mem_req;
  logic [18:0] mem_addr;
  logic        mem_rvalid;
  logic [35:0] mem_rdata;
  logic [23:0] rgb_out;
  logic        out_de, out_hs, out_vs;

  sprite_fetch_palette #(.MEM_LAT(MEM_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .spr_base(spr_base), .spr_x(spr_x),
    .spr_y(spr_y), .transp_en(transp_en), .bg_rgb(bg_rgb), .pal_we(pal_we),
    .pal_waddr(pal_waddr), .pal_wdata(pal_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rgb_out(rgb_out), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_on  = 1'b0;
  bit done    = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // configuration and models
  int          c_sx, c_sy, c_base;
  bit          c_tr, c_ph;
  logic [23:0] c_bg;
  logic [23:0] pal_m [64];

  bit          e_valid [64];
  logic [23:0] e_rgb   [64];
  string       e_tag   [64];
  logic [2:0]  e_syn   [64];
  bit          e_req   [64];
  logic [18:0] e_addr  [64];

  function automatic logic [35:0] mem_word(input logic [18:0] a);
    logic [63:0] h;
    h = {45'd0, a} * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 31);
    return h[47:12];
  endfunction

  function automatic int pix_of(input int base, input int idx);
    logic [18:0] w;
    logic [35:0] d;
    w = 19'(base + idx / 6);
    d = mem_word(w);
    return int'((d >> (30 - 6 * (idx % 6))) & 36'h3F);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // memory model with fixed latency, driven away from the active edge
  bit          rv_p [MEM_LAT+1];
  logic [35:0] rd_p [MEM_LAT+1];
  always @(negedge clk) begin
    for (int k = MEM_LAT; k > 0; k--) begin
      rv_p[k] = rv_p[k-1];
      rd_p[k] = rd_p[k-1];
    end
    rv_p[0]    = rst_n && mem_req;
    rd_p[0]    = mem_word(mem_addr);
    mem_rvalid = rv_p[MEM_LAT];
    mem_rdata  = rd_p[MEM_LAT];
  end

  // output comparison
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      int q, p;
      q = (cyc - 1) & 63;
      p = (cyc - TOT) & 63;
      if (e_valid[q]) begin
        check(mem_req == e_req[q], e_req[q] ? "R2" : "R1,R3", "mem_req",
              36'(mem_req), 36'(e_req[q]));
        if (e_req[q])
          check(mem_addr == e_addr[q], "R2", "mem_addr", 36'(mem_addr), 36'(e_addr[q]));
      end
      if (e_valid[p]) begin
        check(rgb_out == e_rgb[p], e_tag[p], "rgb_out", 36'(rgb_out), 36'(e_rgb[p]));
        check({out_hs, out_vs, out_de} == e_syn[p], "R8", "sync",
              36'({out_hs, out_vs, out_de}), 36'(e_syn[p]));
      end
    end
  end

  bit          nx_we;
  logic [5:0]  nx_wa;
  logic [23:0] nx_wd;

  task automatic step(input int x, input int y, input bit de, input bit hs, input bit vs);
    int c, col, row, idx, sl, px;
    bit inw;
    @(negedge clk);
    pix_x = 10'(x); pix_y = 10'(y);
    pix_de = de; pix_hs = hs; pix_vs = vs;
    pal_we = nx_we; pal_waddr = nx_wa; pal_wdata = nx_wd;
    if (nx_we) pal_m[nx_wa] = nx_wd;
    c   = cyc & 63;
    inw = de && x >= c_sx && x < c_sx + 64 && y >= c_sy && y < c_sy + 64;
    e_syn[c]  = {hs, vs, de};
    e_req[c]  = 1'b0;
    e_addr[c] = '0;
    e_rgb[c]  = c_bg;
    e_tag[c]  = "R6";
    if (inw) begin
      col = x - c_sx; row = y - c_sy;
      idx = row * 64 + col;
      sl  = idx % 6;
      px  = pix_of(c_base, idx);
      e_req[c]  = (col == 0) || (sl == 0);
      e_addr[c] = 19'(c_base + idx / 6);
      if (c_tr && px == 0) begin
        e_tag[c] = "R7";
      end else begin
        e_rgb[c] = pal_m[px];
        if (c_ph)          e_tag[c] = "R9";
        else if (px == 0)  e_tag[c] = "R7";
        else if (sl > col) e_tag[c] = "R10";
        else               e_tag[c] = "R4,R5";
      end
    end
    e_valid[c] = 1'b1;
  endtask

  task automatic pal_write(input int a, input logic [23:0] d);
    nx_we = 1'b1; nx_wa = 6'(a); nx_wd = d;
    step(0, 0, 1'b0, 1'b0, 1'b0);
    nx_we = 1'b0;
  endtask

  task automatic scan(input int sx, input int sy, input int base, input bit tr,
                      input logic [23:0] bg, input bit ph);
    int x0, x1, y0, y1;
    for (int k = 0; k < 64; k++) e_valid[k] = 1'b0;
    c_sx = sx; c_sy = sy; c_base = base; c_tr = tr; c_bg = bg; c_ph = ph;
    spr_x = 10'(sx); spr_y = 10'(sy); spr_base = 19'(base);
    transp_en = tr; bg_rgb = bg;
    repeat (12) step(0, 0, 1'b0, 1'b0, 1'b0);
    x0 = (sx > 2) ? sx - 2 : 0;
    x1 = (sx + 66 > 1023) ? 1023 : sx + 66;
    y0 = (sy > 1) ? sy - 1 : 0;
    y1 = (sy + 64 > 767) ? 767 : sy + 64;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) step(x, y, 1'b1, 1'b0, 1'b0);
      repeat (6) step(0, y, 1'b0, 1'b1, (y == y0));
    end
    repeat (12) step(0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20151));
    for (int k = 0; k < 64; k++) e_valid[k] = 1'b0;
    for (int k = 0; k <= MEM_LAT; k++) begin rv_p[k] = 1'b0; rd_p[k] = '0; end
    rst_n = 1'b0;
    pix_x = '0; pix_y = '0; pix_de = 0; pix_hs = 0; pix_vs = 0;
    spr_x = '0; spr_y = '0; spr_base = '0; transp_en = 0; bg_rgb = '0;
    pal_we = 0; pal_waddr = '0; pal_wdata = '0;
    nx_we = 0; nx_wa = '0; nx_wd = '0;
    c_sx = 2000; c_sy = 2000; c_base = 0; c_tr = 0; c_ph = 0; c_bg = '0;
    mem_rvalid = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(mem_req == 1'b0, "R11", "mem_req", 36'(mem_req), 36'd0);
    check(rgb_out == '0, "R11", "rgb_out", 36'(rgb_out), 36'd0);
    check({out_hs, out_vs, out_de} == 3'b000, "R11", "sync",
          36'({out_hs, out_vs, out_de}), 36'd0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    for (int i = 0; i < 64; i++) pal_write(i, 24'($urandom));
    if (pal_m[0] == '0) pal_write(0, 24'h00A5C3);
    repeat (8) step(0, 0, 1'b0, 1'b0, 1'b0);
    // directed corners
    scan(0, 0, 0, 1'b0, 24'h102030, 1'b0);
    scan(960, 704, 524288 - 300, 1'b1, 24'h0F0F0F, 1'b0);
    scan(7, 3, 524288 - 683, 1'b0, 24'hFFFFFF, 1'b0);
    // random placements
    for (int n = 0; n < 3; n++)
      scan($urandom_range(0, 960), $urandom_range(0, 704), $urandom_range(0, 524287),
           1'($urandom), 24'($urandom), 1'b0);
    // R9: rewrite entries, then show the same sprite again
    for (int i = 0; i < 64; i += 5) pal_write(i, 24'($urandom) | 24'h1);
    scan(100, 200, 4321, 1'b0, 24'h00FF00, 1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule